// File: doc/BRIEF.md
# Global OUT NAK Responder

This block sits between the token/data decoder of a USB device controller and its shared receive FIFO. It decides, for every OUT or SETUP packet on any endpoint, which handshake is returned to the host and whether the packet's data words are written into the receive FIFO. Software can place the whole device in a global OUT NAK mode. In that mode OUT traffic is refused or dropped, while SETUP packets still reach the FIFO.

Software raises the set control for one cycle to request the mode. The block does not switch in the middle of a packet. It waits for the packet in flight to finish, then pushes a single marker word into the receive FIFO so that the FIFO reader can see where the mode began. After that it raises its effective-status flag. A one-cycle clear control leaves the mode and restores the normal decision, which depends on the free space reported by the FIFO.

Top module: `out_nak_gate`

## Requirements
- R1: While reset is held and after it is released, with no traffic, `hs_o` is 2'b00 (no handshake), `fifo_we_o` is 0 and `nak_eff_o` is 0.
- R2: Outside the mode, a non-isochronous OUT token (`tok_kind_i` = 2'b01, `tok_iso_i` = 0) gets ACK (`hs_o` = 2'b01) if `fifo_free_i` >= `tok_len_i`, and all its data words are written. Otherwise it gets NAK (`hs_o` = 2'b10) and none of its words are written.
- R3: Outside the mode, an isochronous OUT token gets no handshake (2'b00). Its data words are written if `fifo_free_i` >= `tok_len_i`, and dropped otherwise.
- R4: A SETUP token (`tok_kind_i` = 2'b10) always gets ACK, and its data words are written, whether or not the mode is in effect.
- R5: A set pulse sampled on clock edge n while no packet is in flight makes `fifo_we_o` rise after edge n+1 with `fifo_wdata_o` equal to `MARK_WORD`. `nak_eff_o` then rises after edge n+2.
- R6: A set pulse sampled while a packet is in flight leaves that packet's handshake and writes unchanged. The marker is written two cycles after the last data word of that packet is sampled.
- R7: While the mode is in effect, a non-isochronous OUT token gets NAK whatever the free space, and none of its words are written.
- R8: While the mode is in effect, an isochronous OUT token gets no handshake, and none of its words are written.
- R9: A clear pulse returns the block to normal operation for any token sampled from the next edge on, and `nak_eff_o` falls after the edge that samples the clear. A clear sampled together with a set wins, so no marker follows. A clear sampled while the marker is being issued still lets that marker out, but `nak_eff_o` does not rise.
- R10: A set pulse while the mode is already in effect writes no second marker.
- R11: The handshake appears on `hs_o` for exactly the one cycle after the token is sampled and is 2'b00 in every other cycle. A data word sampled on an edge appears on the FIFO port after that same edge. Token kinds 2'b00 and 2'b11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nak_set_i | input | 1 | One-cycle request to enter global OUT NAK mode |
| nak_clr_i | input | 1 | One-cycle request to leave the mode |
| tok_valid_i | input | 1 | Token present this cycle |
| tok_kind_i | input | 2 | Token kind: 01 OUT, 10 SETUP, others ignored |
| tok_iso_i | input | 1 | OUT token targets an isochronous endpoint |
| tok_len_i | input | LEN_W | Packet length in words |
| dat_valid_i | input | 1 | Data word present |
| dat_last_i | input | 1 | Data word ends the packet |
| dat_i | input | DW | Data word |
| fifo_free_i | input | FREE_W | Free words in the receive FIFO |
| hs_o | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK |
| fifo_we_o | output | 1 | Receive FIFO write strobe |
| fifo_wdata_o | output | DW | Receive FIFO write word |
| nak_eff_o | output | 1 | Global OUT NAK mode is in effect |

## Verification
The assertions assume a well-formed packet stream:
- A token is followed by exactly `tok_len_i` data words, at least one, beginning no earlier than the next cycle.
- The last word carries `dat_last_i`.
- No new token arrives until that last word has been sampled.
- The FIFO reports enough room for the marker word when the mode is requested.

Under these assumptions the marker and a data word can never compete for the write port. The bench keeps within them because its packet task always sends the token, then the words back to back, then an idle cycle. Set and clear pulses are placed only on idle cycles or between the words of a packet.

// File: rtl/onak_pkg.sv
package onak_pkg;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_OUT   = 2'b01,
    TK_SETUP = 2'b10,
    TK_RSVD  = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    M_IDLE,
    M_PEND,
    M_MARK,
    M_HOLD
  } mode_e;

  // enough room for the whole packet
  function automatic logic room_ok(input int unsigned free_w, input int unsigned need_w);
    return free_w >= need_w;
  endfunction

  function automatic hs_e pick_hs(input tok_e kind, input logic iso,
                                  input logic gated, input logic room);
    if (kind == TK_SETUP) return HS_ACK;
    if (kind != TK_OUT || iso) return HS_NONE;
    if (gated || !room) return HS_NAK;
    return HS_ACK;
  endfunction

  function automatic logic pick_pass(input tok_e kind, input logic gated, input logic room);
    if (kind == TK_SETUP) return 1'b1;
    return (kind == TK_OUT) && !gated && room;
  endfunction

endpackage

// File: rtl/onak_mode_fsm.sv
module onak_mode_fsm
  import onak_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  output logic gated_o,
  output logic mark_req_o,
  output logic eff_o
);

  mode_e st_q, st_d;
  logic  eff_q;

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d = M_IDLE;
    end else begin
      case (st_q)
        M_IDLE:  if (set_i) st_d = busy_i ? M_PEND : M_MARK;
        M_PEND:  if (!busy_i) st_d = M_MARK;
        M_MARK:  st_d = M_HOLD;
        M_HOLD:  st_d = M_HOLD;
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      eff_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eff_q <= (st_q == M_HOLD) && !clr_i;
    end
  end

  assign gated_o    = (st_q == M_MARK) || (st_q == M_HOLD);
  assign mark_req_o = (st_q == M_MARK);
  assign eff_o      = eff_q;

  // R5
  mark_leads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_MARK) && !clr_i |=> (st_q == M_HOLD));

  // R6
  pend_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_PEND) && busy_i && !clr_i |=> (st_q == M_PEND) && !mark_req_o);

  // R9
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (st_q == M_IDLE) && !eff_o);

  // R10
  hold_no_remark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_HOLD) |=> !mark_req_o);

endmodule

// File: rtl/onak_pkt_track.sv
module onak_pkt_track
  import onak_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int FREE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic              tok_iso_i,
  input  logic [LEN_W-1:0]  tok_len_i,
  input  logic [FREE_W-1:0] free_i,
  input  logic              gated_i,
  input  logic              dat_valid_i,
  input  logic              dat_last_i,
  output hs_e               hs_o,
  output logic              busy_o,
  output logic              wr_dat_o
);

  tok_e kind_w;
  logic tok_go, room;
  logic busy_q, pass_q, setup_q;
  hs_e  hs_q;

  assign kind_w = tok_e'(tok_kind_i);
  assign tok_go = tok_valid_i && (kind_w == TK_OUT || kind_w == TK_SETUP);
  assign room   = room_ok(32'(free_i), 32'(tok_len_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HS_NONE;
      busy_q  <= 1'b0;
      pass_q  <= 1'b0;
      setup_q <= 1'b0;
    end else begin
      hs_q <= tok_go ? pick_hs(kind_w, tok_iso_i, gated_i, room) : HS_NONE;
      if (tok_go) begin
        busy_q  <= 1'b1;
        pass_q  <= pick_pass(kind_w, gated_i, room);
        setup_q <= (kind_w == TK_SETUP);
      end else if (dat_valid_i && dat_last_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign hs_o     = hs_q;
  assign busy_o   = busy_q || tok_go;
  assign wr_dat_o = dat_valid_i && busy_q && pass_q;

  // R7
  gated_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid_i && kind_w == TK_OUT && !tok_iso_i && gated_i |=> hs_o == HS_NAK);

  // R8
  iso_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid_i && kind_w == TK_OUT && tok_iso_i |=> hs_o == HS_NONE);

  // R4
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid_i && kind_w == TK_SETUP |=> hs_o == HS_ACK);

  // R7
  gated_no_out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat_o && gated_i |-> setup_q);

  // R11
  hs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid_i |=> hs_o == HS_NONE);

endmodule

// File: rtl/onak_wr_port.sv
module onak_wr_port #(
  parameter int          DW        = 32,
  parameter logic [DW-1:0] MARK_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark_req_i,
  input  logic          wr_dat_i,
  input  logic [DW-1:0] dat_i,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o    <= mark_req_i || wr_dat_i;
      wdata_o <= mark_req_i ? MARK_WORD : dat_i;
    end
  end

  // R5
  no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_req_i && wr_dat_i));

endmodule

// File: rtl/out_nak_gate.sv
module out_nak_gate #(
  parameter int            DW        = 32,
  parameter int            LEN_W     = 5,
  parameter int            FREE_W    = 8,
  parameter logic [DW-1:0] MARK_WORD = 32'hC0DE_0A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nak_set_i,
  input  logic              nak_clr_i,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic              tok_iso_i,
  input  logic [LEN_W-1:0]  tok_len_i,
  input  logic              dat_valid_i,
  input  logic              dat_last_i,
  input  logic [DW-1:0]     dat_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  output logic [1:0]        hs_o,
  output logic              fifo_we_o,
  output logic [DW-1:0]     fifo_wdata_o,
  output logic              nak_eff_o
);

  import onak_pkg::*;

  logic gated_w, mark_req_w, busy_w, wr_dat_w;
  hs_e  hs_w;

  onak_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (nak_set_i),
    .clr_i      (nak_clr_i),
    .busy_i     (busy_w),
    .gated_o    (gated_w),
    .mark_req_o (mark_req_w),
    .eff_o      (nak_eff_o)
  );

  onak_pkt_track #(.LEN_W(LEN_W), .FREE_W(FREE_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_valid_i (tok_valid_i),
    .tok_kind_i  (tok_kind_i),
    .tok_iso_i   (tok_iso_i),
    .tok_len_i   (tok_len_i),
    .free_i      (fifo_free_i),
    .gated_i     (gated_w),
    .dat_valid_i (dat_valid_i),
    .dat_last_i  (dat_last_i),
    .hs_o        (hs_w),
    .busy_o      (busy_w),
    .wr_dat_o    (wr_dat_w)
  );

  onak_wr_port #(.DW(DW), .MARK_WORD(MARK_WORD)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_req_i (mark_req_w),
    .wr_dat_i   (wr_dat_w),
    .dat_i      (dat_i),
    .we_o       (fifo_we_o),
    .wdata_o    (fifo_wdata_o)
  );

  assign hs_o = hs_w;

  // R5
  marker_before_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_eff_o) |-> $past(fifo_we_o && fifo_wdata_o == MARK_WORD));

endmodule

// File: tb/out_nak_gate_bench.sv
module out_nak_gate_bench;

  localparam logic [31:0] MARK = 32'hC0DE_0A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nak_set_i = 1'b0, nak_clr_i = 1'b0;
  logic        tok_valid_i = 1'b0, tok_iso_i = 1'b0;
  logic [1:0]  tok_kind_i = 2'b00;
  logic [4:0]  tok_len_i = '0;
  logic        dat_valid_i = 1'b0, dat_last_i = 1'b0;
  logic [31:0] dat_i = '0;
  logic [7:0]  fifo_free_i = '0;
  logic [1:0]  hs_o;
  logic        fifo_we_o, nak_eff_o;
  logic [31:0] fifo_wdata_o;

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  int    seq = 0;

  always #5 clk = ~clk;

  out_nak_gate u_out_nak_gate (
    .clk(clk), .rst_n(rst_n), .nak_set_i(nak_set_i), .nak_clr_i(nak_clr_i),
    .tok_valid_i(tok_valid_i), .tok_kind_i(tok_kind_i), .tok_iso_i(tok_iso_i),
    .tok_len_i(tok_len_i), .dat_valid_i(dat_valid_i), .dat_last_i(dat_last_i),
    .dat_i(dat_i), .fifo_free_i(fifo_free_i), .hs_o(hs_o), .fifo_we_o(fifo_we_o),
    .fifo_wdata_o(fifo_wdata_o), .nak_eff_o(nak_eff_o)
  );

  // reference model: 0 normal, 1 waiting, 2 marker due, 3 in force
  int          m_mode = 0;
  bit          m_inpkt = 0, m_keep = 0;
  logic [1:0]  e_hs = 2'b00;
  bit          e_we = 0, e_eff = 0;
  logic [31:0] e_wd = '0;

  always @(posedge clk) begin
    bit started, refuse, fits;
    int nxt;
    if (!rst_n) begin
      m_mode = 0; m_inpkt = 0; m_keep = 0;
      e_hs = 2'b00; e_we = 0; e_eff = 0; e_wd = '0;
    end else begin
      started = tok_valid_i && (tok_kind_i == 2'b01 || tok_kind_i == 2'b10);
      refuse  = (m_mode >= 2);
      fits    = int'(fifo_free_i) >= int'(tok_len_i);
      e_we = (m_mode == 2) || (dat_valid_i && m_inpkt && m_keep);
      e_wd = (m_mode == 2) ? MARK : dat_i;
      e_eff = (m_mode == 3) && !nak_clr_i;
      e_hs = 2'b00;
      if (started) begin
        if (tok_kind_i == 2'b10) begin e_hs = 2'b01; m_keep = 1; end
        else if (tok_iso_i) begin e_hs = 2'b00; m_keep = !refuse && fits; end
        else if (refuse || !fits) begin e_hs = 2'b10; m_keep = 0; end
        else begin e_hs = 2'b01; m_keep = 1; end
      end
      nxt = m_mode;
      if (nak_clr_i) nxt = 0;
      else if (m_mode == 0 && nak_set_i) nxt = (m_inpkt || started) ? 1 : 2;
      else if (m_mode == 1 && !(m_inpkt || started)) nxt = 2;
      else if (m_mode == 2) nxt = 3;
      m_mode = nxt;
      if (started) m_inpkt = 1;
      else if (dat_valid_i && dat_last_i) m_inpkt = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "hs", 32'(hs_o), 32'(e_hs));
      chk(cur_req, "we", 32'(fifo_we_o), 32'(e_we));
      if (e_we) chk(cur_req, "wdata", fifo_wdata_o, e_wd);
      chk(cur_req, "eff", 32'(nak_eff_o), 32'(e_eff));
    end
  end

  task automatic send_pkt(input string req, input logic [1:0] kind, input logic iso,
                          input int len, input int free, input int set_at = -1);
    cur_req = req;
    @(negedge clk);
    tok_valid_i = 1'b1; tok_kind_i = kind; tok_iso_i = iso;
    tok_len_i = 5'(len); fifo_free_i = 8'(free);
    @(negedge clk);
    tok_valid_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      seq++;
      dat_valid_i = 1'b1; dat_i = 32'hD000_0000 + 32'(seq); dat_last_i = (i == len - 1);
      nak_set_i = (i == set_at);
      @(negedge clk);
    end
    dat_valid_i = 1'b0; dat_last_i = 1'b0; nak_set_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input string req, input bit s, input bit c);
    cur_req = req;
    @(negedge clk);
    nak_set_i = s; nak_clr_i = c;
    @(negedge clk);
    nak_set_i = 1'b0; nak_clr_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "hs at reset", 32'(hs_o), 32'd0);
    chk("R1", "we at reset", 32'(fifo_we_o), 32'd0);
    chk("R1", "eff at reset", 32'(nak_eff_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send_pkt("R2", 2'b01, 1'b0, 4, 10);
    send_pkt("R2", 2'b01, 1'b0, 8, 5);
    send_pkt("R2", 2'b01, 1'b0, 6, 6);
    send_pkt("R3", 2'b01, 1'b1, 3, 10);
    send_pkt("R3", 2'b01, 1'b1, 6, 2);
    send_pkt("R4", 2'b10, 1'b0, 2, 0);
    send_pkt("R11", 2'b11, 1'b0, 2, 50);

    pulse("R5", 1'b1, 1'b0);
    chk("R5", "eff after marker", 32'(nak_eff_o), 32'd1);
    send_pkt("R7", 2'b01, 1'b0, 3, 200);
    send_pkt("R8", 2'b01, 1'b1, 3, 200);
    send_pkt("R4", 2'b10, 1'b0, 3, 200);
    pulse("R10", 1'b1, 1'b0);
    pulse("R9", 1'b0, 1'b1);
    chk("R9", "eff after clear", 32'(nak_eff_o), 32'd0);
    send_pkt("R9", 2'b01, 1'b0, 2, 20);

    send_pkt("R6", 2'b01, 1'b0, 5, 30, 1);
    repeat (3) @(negedge clk);
    chk("R6", "eff after deferred entry", 32'(nak_eff_o), 32'd1);
    send_pkt("R7", 2'b01, 1'b0, 2, 31);
    pulse("R9", 1'b0, 1'b1);
    pulse("R9", 1'b1, 1'b1);
    chk("R9", "clear beats set", 32'(nak_eff_o), 32'd0);

    // R9 clear during marker cycle
    cur_req = "R9";
    @(negedge clk); nak_set_i = 1'b1;
    @(negedge clk); nak_set_i = 1'b0; nak_clr_i = 1'b1;
    @(negedge clk); nak_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "eff stays low", 32'(nak_eff_o), 32'd0);
    send_pkt("R2", 2'b01, 1'b0, 3, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule